// File: doc/BRIEF.md
# Coin-Accepting Drink Vending Controller

This block is a synchronous finite state machine that sells a single drink priced at 150 units. It accepts two kinds of coin, worth 50 and 100 units. Each coin arrives as a one-cycle strobe on its own input. The machine remembers the credit paid so far in the current sale. Its response to a coin therefore depends on both the coin and the credit already held.

When the credit reaches or passes the price, the block raises a one-cycle vend pulse in the same cycle as the final coin. If the buyer has overpaid by 50 units, it also raises a one-cycle change pulse in that cycle. It then returns to idle, ready for the next sale. The current credit code is visible on an output so that the surrounding logic can see the held credit.

Top module: `vend_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `creditCode` reads 0 and `vendOut` and `changeOut` are low.
- R2: `creditCode` uses fixed codes: 0 for idle with no credit, 2 for 50 units held, and 1 for 100 units held. Code 3 never appears.
- R3: From idle, a 50 coin moves to code 2 and a 100 coin moves to code 1. Neither output pulses.
- R4: With 50 units held, a 50 coin moves to code 1 with no output. A 100 coin pulses `vendOut` without `changeOut` and moves to code 0.
- R5: With 100 units held, a 50 coin pulses `vendOut` without `changeOut` and moves to code 0.
- R6: With 100 units held, a 100 coin pulses both `vendOut` and `changeOut` in the same cycle and moves to code 0.
- R7: In a cycle with no coin strobe, the credit code holds and both outputs stay low.
- R8: A cycle with both `coinFifty` and `coinHundred` high is ignored. The credit code holds and both outputs stay low.
- R9: `vendOut` and `changeOut` are combinational (Mealy) outputs. They are high only during the cycle of the coin that completes payment, and they last exactly one cycle.
- R10: A synchronous reset asserted during a completing coin suppresses both outputs and returns the credit code to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coinFifty | input | 1 | One-cycle strobe: a 50-unit coin was inserted |
| coinHundred | input | 1 | One-cycle strobe: a 100-unit coin was inserted |
| vendOut | output | 1 | One-cycle pulse: release the drink |
| changeOut | output | 1 | One-cycle pulse: return 50 units |
| creditCode | output | 2 | Held credit: 0 idle, 2 = 50 units, 1 = 100 units |

## Verification
The assertions check the following on every cycle:
- the credit code stays within the three legal values;
- a change pulse never appears without a vend pulse;
- every vend is followed by idle;
- a cycle with no coin leaves the state unchanged;
- idle never vends;
- a vend pulse never repeats on the next cycle.

Only the bench scenarios can show that each coin, from each credit level, reaches the right code and the right pulse combination. The same holds for the rejected double strobe and for a reset that arrives together with a paying coin.

// File: rtl/vend_pkg.sv
package vend_pkg;
  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    ST_IDLE    = 2'd0,
    ST_HUNDRED = 2'd1,
    ST_FIFTY   = 2'd2
  } credit_e;

  typedef enum logic [1:0] {
    COIN_NONE = 2'd0,
    COIN_LO   = 2'd1,
    COIN_HI   = 2'd2
  } coin_e;

  typedef struct packed {
    logic vend;
    logic change;
  } strobe_t;
endpackage

// File: rtl/vend_datapath.sv
module vend_datapath
  import vend_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    coinFifty,
  input  logic    coinHundred,
  input  strobe_t strobes,
  output coin_e   coinKind,
  output logic    vendOut,
  output logic    changeOut
);
  // Classify the coin strobes; a double strobe is rejected as no coin.
  always_comb begin
    unique case ({coinHundred, coinFifty})
      2'b01:   coinKind = COIN_LO;
      2'b10:   coinKind = COIN_HI;
      default: coinKind = COIN_NONE;
    endcase
  end

  // Mealy pulses, held low while reset is applied.
  assign vendOut   = strobes.vend   && !rst;
  assign changeOut = strobes.change && !rst;

  // A sale always returns to idle, so a vend cannot repeat on the next cycle.
  p_vend_single_r9: assert property (@(posedge clk) disable iff (rst)
    vendOut |=> !vendOut);
  p_change_single_r9: assert property (@(posedge clk) disable iff (rst)
    changeOut |=> !changeOut);
endmodule

// File: rtl/vend_control.sv
module vend_control
  import vend_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  coin_e   coinKind,
  output strobe_t strobes,
  output credit_e stateQ
);
  credit_e stateD;

  always_comb begin
    stateD         = stateQ;
    strobes.vend   = 1'b0;
    strobes.change = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (coinKind == COIN_LO)      stateD = ST_FIFTY;
        else if (coinKind == COIN_HI) stateD = ST_HUNDRED;
      end
      ST_FIFTY: begin
        if (coinKind == COIN_LO) stateD = ST_HUNDRED;
        else if (coinKind == COIN_HI) begin
          stateD       = ST_IDLE;
          strobes.vend = 1'b1;
        end
      end
      ST_HUNDRED: begin
        if (coinKind != COIN_NONE) begin
          stateD         = ST_IDLE;
          strobes.vend   = 1'b1;
          strobes.change = (coinKind == COIN_HI);
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  p_legal_code_r2: assert property (@(posedge clk) disable iff (rst)
    stateQ != 2'd3);
  p_change_with_vend_r6: assert property (@(posedge clk) disable iff (rst)
    strobes.change |-> strobes.vend);
  p_vend_to_idle_r9: assert property (@(posedge clk) disable iff (rst)
    strobes.vend |=> stateQ == ST_IDLE);
  p_no_coin_hold_r7: assert property (@(posedge clk) disable iff (rst)
    coinKind == COIN_NONE |=> $stable(stateQ));
  p_idle_no_vend_r3: assert property (@(posedge clk) disable iff (rst)
    stateQ == ST_IDLE |-> !strobes.vend);
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              coinFifty,
  input  logic              coinHundred,
  output logic              vendOut,
  output logic              changeOut,
  output logic [CODE_W-1:0] creditCode
);
  coin_e   coinKind;
  strobe_t strobes;
  credit_e stateQ;

  vend_datapath u_dp (
    .clk(clk), .rst(rst), .coinFifty(coinFifty), .coinHundred(coinHundred),
    .strobes(strobes), .coinKind(coinKind), .vendOut(vendOut), .changeOut(changeOut)
  );

  vend_control u_ctl (
    .clk(clk), .rst(rst), .coinKind(coinKind), .strobes(strobes), .stateQ(stateQ)
  );

  assign creditCode = stateQ;
endmodule

// File: tb/tb_vend_ctrl.sv
module tb_vend_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coinFifty = 1'b0;
  logic coinHundred = 1'b0;
  logic vendOut, changeOut;
  logic [1:0] creditCode;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vend_ctrl dut (
    .clk(clk), .rst(rst), .coinFifty(coinFifty), .coinHundred(coinHundred),
    .vendOut(vendOut), .changeOut(changeOut), .creditCode(creditCode)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle of coins, check Mealy outputs before the edge and code after it.
  task automatic step(input logic f, input logic h, input logic eV, input logic eC,
                      input logic [1:0] eCode, input string req);
    @(negedge clk);
    coinFifty = f; coinHundred = h;
    #3;
    check({req, " vend"}, {1'b0, vendOut}, {1'b0, eV});
    check({req, " change"}, {1'b0, changeOut}, {1'b0, eC});
    @(posedge clk);
    #1;
    coinFifty = 1'b0; coinHundred = 1'b0;
    #1;
    check({req, " code"}, creditCode, eCode);
    check({req, " vend one cycle"}, {1'b0, vendOut}, 2'd0);
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic testReset();  // R1
    @(negedge clk);
    check("R1 code", creditCode, 2'd0);
    check("R1 vend", {1'b0, vendOut}, 2'd0);
    doReset();
    #1 check("R1 code after", creditCode, 2'd0);
  endtask

  task automatic testFromIdle();  // R2 R3
    step(1, 0, 0, 0, 2'd2, "R3 fifty from idle");
    doReset();
    step(0, 1, 0, 0, 2'd1, "R3 hundred from idle R2");
    doReset();
  endtask

  task automatic testFromFifty();  // R4
    step(1, 0, 0, 0, 2'd2, "R4 setup");
    step(1, 0, 0, 0, 2'd1, "R4 fifty on fifty");
    doReset();
    step(1, 0, 0, 0, 2'd2, "R4 setup");
    step(0, 1, 1, 0, 2'd0, "R4 hundred on fifty");
  endtask

  task automatic testFromHundred();  // R5 R6
    step(0, 1, 0, 0, 2'd1, "R5 setup");
    step(1, 0, 1, 0, 2'd0, "R5 fifty on hundred");
    step(0, 1, 0, 0, 2'd1, "R6 setup");
    step(0, 1, 1, 1, 2'd0, "R6 hundred on hundred");
    step(1, 0, 0, 0, 2'd2, "R9 next sale starts clean");
    step(1, 0, 0, 0, 2'd1, "R9 three fifties");
    step(1, 0, 1, 0, 2'd0, "R9 third fifty vends");
  endtask

  task automatic testIdleAndBoth();  // R7 R8
    step(1, 0, 0, 0, 2'd2, "R7 setup");
    step(0, 0, 0, 0, 2'd2, "R7 no coin holds");
    step(0, 0, 0, 0, 2'd2, "R7 no coin holds again");
    step(1, 1, 0, 0, 2'd2, "R8 both ignored on fifty");
    step(1, 0, 0, 0, 2'd1, "R8 setup");
    step(1, 1, 0, 0, 2'd1, "R8 both ignored on hundred");
    doReset();
  endtask

  task automatic testResetDuringPay();  // R10
    step(0, 1, 0, 0, 2'd1, "R10 setup");
    @(negedge clk);
    rst = 1'b1; coinHundred = 1'b1;
    #3;
    check("R10 vend suppressed", {1'b0, vendOut}, 2'd0);
    check("R10 change suppressed", {1'b0, changeOut}, 2'd0);
    @(posedge clk); #1;
    coinHundred = 1'b0; rst = 1'b0;
    check("R10 code", creditCode, 2'd0);
  endtask

  initial begin
    fork
      begin
        testReset();
        testFromIdle();
        testFromFifty();
        testFromHundred();
        testIdleAndBoth();
        testResetDuringPay();
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog actual=hung expected=finished");
        end
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule